// File: doc/BRIEF.md
# Successive approximation conversion controller

This block sequences an N-bit successive approximation conversion. When the host requests a conversion, the block puts a trial code on the converter's DAC input and reads the comparator once per clock. It starts with only the most significant bit set. On each clock it decides one bit, from the top bit down. If the comparator says the DAC voltage is above the input, the trial bit is cleared. Otherwise the bit is kept. Then the next lower bit becomes the new trial bit. A conversion takes exactly N clocks, whatever the input.

Each decision appears on a serial output as soon as it is made, qualified by a one-cycle valid strobe, so the code streams out MSB first. The finished code is also held in a result register. The host reads that register one byte at a time through a low-byte enable and a high-byte enable. Two status outputs show progress: `busy` is high while bits are being decided, and `eoc` is high once a code is ready.

The block is driven by a three-state machine:
- ST_IDLE is the state after reset. The transition "accept" moves to ST_TRIAL on `start`.
- ST_TRIAL decides one bit per clock. The transition "finish" moves to ST_DONE when the LSB is decided.
- ST_DONE holds the result. The transition "restart" moves back to ST_TRIAL on `start`.

Top module: `sar_ctrl`

## Requirements
- R1: After reset these outputs are 0: `busy`, `eoc`, `ser_valid` and `dac_code`. `rd_data` reads 0 for either byte.
- R2: When `start` is high at a clock edge while `busy` is low, the next cycle has `busy`=1 and `eoc`=0. In that cycle `dac_code` has only bit N-1 set.
- R3: A conversion keeps `busy` high for exactly N clock cycles. `eoc` rises in the cycle after the last busy cycle.
- R4: `cmp_above`=1 means the DAC level is above the input. At each edge in ST_TRIAL the current trial bit is cleared if `cmp_above`=1 and kept if it is 0, and the next lower bit is set. With a comparator that reports `dac_code > vin`, the final code equals `vin`.
- R5: In the cycle after each decision, `ser_valid`=1 and `ser_bit` holds the decided bit (1 = kept). The bits come out MSB first, one per cycle, for N cycles. `ser_valid` is 0 at all other times.
- R6: The result register changes only at the LSB decision. It keeps its old value during a conversion. `eoc` stays high until the next accepted `start`.
- R7: `start` while `busy` is high is ignored. The conversion neither restarts nor gets longer.
- R8: Byte reads are combinational. With `rd_lo`=1, `rd_data` = result[7:0]. With `rd_hi`=1 and `rd_lo`=0, `rd_data` = result[N-1:8], zero-extended. With neither enable high, `rd_data` = 0. If both are high, the low byte wins.
- R9: `busy` and `eoc` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Conversion request |
| cmp_above | input | 1 | Comparator: DAC level above the analog input |
| dac_code | output | N | Trial code driven to the DAC |
| ser_bit | output | 1 | Most recently decided bit |
| ser_valid | output | 1 | Strobe that qualifies `ser_bit` |
| busy | output | 1 | Conversion in progress |
| eoc | output | 1 | Result ready |
| rd_hi | input | 1 | High-byte read enable |
| rd_lo | input | 1 | Low-byte read enable |
| rd_data | output | 8 | Selected result byte |

## Verification
The assertions check on every cycle:
- `busy` and `eoc` are mutually exclusive;
- `ser_valid` follows a busy cycle;
- every busy run is exactly N cycles long;
- the DAC starts each conversion on the MSB trial;
- the result does not move mid-conversion.

Other properties need an analog input model, so only the bench scenarios can show them:
- the converted code matches that input, for all-zero, all-one, mid-scale and alternating patterns;
- the serial stream matches the code bit for bit;
- a `start` pulse inside a conversion leaves it intact;
- each byte-enable combination selects the right byte.

// File: rtl/sar_pkg.sv
package sar_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_TRIAL = 2'd1,
        ST_DONE  = 2'd2
    } sar_state_e;

    localparam int BYTE_W = 8;
endpackage

// File: rtl/sar_fsm.sv
module sar_fsm
    import sar_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic last_bit,
    output logic load,
    output logic step,
    output logic busy,
    output logic eoc
);
    sar_state_e state_q, state_d;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Transitions: accept, finish, restart
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start)    state_d = ST_TRIAL;
            ST_TRIAL: if (last_bit) state_d = ST_DONE;
            ST_DONE:  if (start)    state_d = ST_TRIAL;
            default:                state_d = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        load = 1'b0;
        step = 1'b0;
        busy = 1'b0;
        eoc  = 1'b0;
        unique case (state_q)
            ST_IDLE:  load = start;
            ST_TRIAL: begin
                step = 1'b1;
                busy = 1'b1;
            end
            ST_DONE:  begin
                load = start;
                eoc  = 1'b1;
            end
            default:  ;
        endcase
    end
endmodule

// File: rtl/sar_datapath.sv
module sar_datapath #(
    parameter int N = 10
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic         step,
    input  logic         cmp_above,
    output logic [N-1:0] trial,
    output logic [N-1:0] result,
    output logic         ser_bit,
    output logic         ser_valid,
    output logic         last_bit
);
    localparam logic [N-1:0] TOP = {1'b1, {(N-1){1'b0}}};

    logic [N-1:0] probe_q;
    logic [N-1:0] trial_next;

    // Keep or clear the current bit, then set the next lower trial bit
    always_comb begin
        trial_next = cmp_above ? (trial & ~probe_q) : trial;
        trial_next = trial_next | (probe_q >> 1);
    end

    assign last_bit = probe_q[0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            trial     <= '0;
            probe_q   <= '0;
            result    <= '0;
            ser_bit   <= 1'b0;
            ser_valid <= 1'b0;
        end else if (load) begin
            trial     <= TOP;
            probe_q   <= TOP;
            ser_valid <= 1'b0;
        end else if (step) begin
            trial     <= trial_next;
            probe_q   <= probe_q >> 1;
            ser_bit   <= ~cmp_above;
            ser_valid <= 1'b1;
            if (probe_q[0]) result <= trial_next;
        end else begin
            ser_valid <= 1'b0;
        end
    end
endmodule

// File: rtl/sar_readout.sv
module sar_readout #(
    parameter int N  = 10,
    parameter int BW = 8
) (
    input  logic [N-1:0]  result,
    input  logic          rd_hi,
    input  logic          rd_lo,
    output logic [BW-1:0] rd_data
);
    localparam int WW = 2 * BW;

    logic [WW-1:0] wide;

    generate
        if (N < WW) begin : g_pad
            assign wide = {{(WW-N){1'b0}}, result};
        end else begin : g_full
            assign wide = result[WW-1:0];
        end
    endgenerate

    always_comb begin
        if (rd_lo)      rd_data = wide[BW-1:0];
        else if (rd_hi) rd_data = wide[WW-1:BW];
        else            rd_data = '0;
    end
endmodule

// File: rtl/sar_ctrl.sv
module sar_ctrl #(
    parameter int N = 10
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic         cmp_above,
    output logic [N-1:0] dac_code,
    output logic         ser_bit,
    output logic         ser_valid,
    output logic         busy,
    output logic         eoc,
    input  logic         rd_hi,
    input  logic         rd_lo,
    output logic [7:0]   rd_data
);
    logic         load;
    logic         step;
    logic         last_bit;
    logic [N-1:0] result;

    sar_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .last_bit (last_bit),
        .load     (load),
        .step     (step),
        .busy     (busy),
        .eoc      (eoc)
    );

    sar_datapath #(.N(N)) u_dp (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .step      (step),
        .cmp_above (cmp_above),
        .trial     (dac_code),
        .result    (result),
        .ser_bit   (ser_bit),
        .ser_valid (ser_valid),
        .last_bit  (last_bit)
    );

    sar_readout #(.N(N), .BW(8)) u_rd (
        .result  (result),
        .rd_hi   (rd_hi),
        .rd_lo   (rd_lo),
        .rd_data (rd_data)
    );
endmodule

// File: rtl/sar_ctrl_chk.sv
module sar_ctrl_chk #(
    parameter int N = 10
) (
    input logic         clk,
    input logic         rst_n,
    input logic         busy,
    input logic         eoc,
    input logic         ser_valid,
    input logic [N-1:0] dac_code,
    input logic [N-1:0] result,
    input logic         rd_hi,
    input logic         rd_lo,
    input logic [7:0]   rd_data
);
    localparam logic [N-1:0] TOP = {1'b1, {(N-1){1'b0}}};
    localparam int CW = $clog2(N + 2) + 1;

    logic [CW-1:0] run_len;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    run_len <= '0;
        else if (busy) run_len <= run_len + 1'b1;
        else           run_len <= '0;
    end

    a_r9_busy_eoc_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && eoc));

    a_r5_valid_follows_busy: assert property (@(posedge clk) disable iff (!rst_n)
        ser_valid |-> $past(busy));

    a_r3_run_length: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (run_len == CW'(N)) && eoc);

    a_r2_msb_trial: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> dac_code == TOP);

    a_r6_result_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(result));

    a_r8_idle_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_hi && !rd_lo) |-> rd_data == 8'd0);
endmodule

bind sar_ctrl sar_ctrl_chk #(.N(N)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy      (busy),
    .eoc       (eoc),
    .ser_valid (ser_valid),
    .dac_code  (dac_code),
    .result    (result),
    .rd_hi     (rd_hi),
    .rd_lo     (rd_lo),
    .rd_data   (rd_data)
);

// File: tb/sar_ctrl_tb.sv
module sar_ctrl_tb;
    localparam int N = 10;
    localparam logic [N-1:0] TOP = {1'b1, {(N-1){1'b0}}};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic rd_hi = 1'b0;
    logic rd_lo = 1'b0;
    logic [N-1:0] vin = '0;
    logic cmp_above;
    logic [N-1:0] dac_code;
    logic ser_bit, ser_valid, busy, eoc;
    logic [7:0] rd_data;

    int checks = 0;
    int errors = 0;

    logic exp_bits[$];
    logic [N-1:0] exp_res[$];
    logic [N-1:0] assembled = '0;
    logic eoc_prev = 1'b0;

    always #10 clk = ~clk;

    // Comparator model
    assign cmp_above = (dac_code > vin);

    sar_ctrl #(.N(N)) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .cmp_above (cmp_above),
        .dac_code  (dac_code),
        .ser_bit   (ser_bit),
        .ser_valid (ser_valid),
        .busy      (busy),
        .eoc       (eoc),
        .rd_hi     (rd_hi),
        .rd_lo     (rd_lo),
        .rd_data   (rd_data)
    );

    task automatic check(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    // Monitor: serial stream and finished codes
    always @(negedge clk) begin
        if (rst_n) begin
            if (ser_valid) begin
                if (exp_bits.size() == 0) begin
                    check(1'b0, "R5 unexpected ser_valid", 1, 0);
                end else begin
                    logic e;
                    e = exp_bits.pop_front();
                    check(ser_bit == e, "R5 serial bit", int'(ser_bit), int'(e));
                    assembled = {assembled[N-2:0], ser_bit};
                end
            end
            if (eoc && !eoc_prev) begin
                if (exp_res.size() == 0) begin
                    check(1'b0, "R4 unexpected eoc", 1, 0);
                end else begin
                    logic [N-1:0] r;
                    r = exp_res.pop_front();
                    check(assembled == r, "R4 converted code", int'(assembled), int'(r));
                end
            end
            eoc_prev = eoc;
        end
    end

    task automatic read_bytes(input logic [N-1:0] v);
        logic [15:0] w;
        w = 16'(v);
        rd_lo = 1'b1;
        rd_hi = 1'b0;
        #1;
        check(rd_data == w[7:0], "R8 low byte", int'(rd_data), int'(w[7:0]));
        rd_lo = 1'b0;
        rd_hi = 1'b1;
        #1;
        check(rd_data == w[15:8], "R8 high byte", int'(rd_data), int'(w[15:8]));
        rd_lo = 1'b1;
        #1;
        check(rd_data == w[7:0], "R8 both enables low wins", int'(rd_data), int'(w[7:0]));
        rd_lo = 1'b0;
        rd_hi = 1'b0;
        #1;
        check(rd_data == 8'd0, "R8 no enable", int'(rd_data), 0);
    endtask

    // Driver: push expectations, run one conversion
    task automatic convert(input logic [N-1:0] v, input bit poke_mid, input logic [N-1:0] prev);
        int cnt;
        vin = v;
        for (int i = N - 1; i >= 0; i--) exp_bits.push_back(v[i]);
        exp_res.push_back(v);
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(busy && !eoc, "R2 busy after start", int'({busy, eoc}), 2);
        check(dac_code == TOP, "R2 MSB trial", int'(dac_code), int'(TOP));
        cnt = 1;
        while (!eoc && cnt < 4 * N) begin
            if (cnt == 3) begin
                rd_lo = 1'b1;
                rd_hi = 1'b1;
                #1;
                check(rd_data == 8'(16'(prev)), "R6 result held mid-conversion",
                      int'(rd_data), int'(8'(16'(prev))));
                rd_lo = 1'b0;
                rd_hi = 1'b0;
                if (poke_mid) start = 1'b1;
            end
            @(negedge clk);
            start = 1'b0;
            cnt++;
        end
        check(cnt == N + 1, poke_mid ? "R7 mid start ignored, length" : "R3 conversion length",
              cnt, N + 1);
        check(!busy, "R9 busy low at eoc", int'(busy), 0);
        read_bytes(v);
        repeat (3) @(negedge clk);
        check(eoc && !busy, "R6 eoc holds", int'(eoc), 1);
        check(!ser_valid, "R5 no strobe after conversion", int'(ser_valid), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(!busy && !eoc, "R1 status after reset", int'({busy, eoc}), 0);
        check(dac_code == '0, "R1 dac after reset", int'(dac_code), 0);
        check(!ser_valid, "R1 strobe after reset", int'(ser_valid), 0);
        rd_lo = 1'b1;
        #1;
        check(rd_data == 8'd0, "R1 low byte after reset", int'(rd_data), 0);
        rd_lo = 1'b0;
        rd_hi = 1'b1;
        #1;
        check(rd_data == 8'd0, "R1 high byte after reset", int'(rd_data), 0);
        rd_hi = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy && !eoc, "R1 idle without start", int'({busy, eoc}), 0);

        convert(10'h000, 1'b0, 10'h000);
        convert(10'h3FF, 1'b0, 10'h000);
        convert(10'h200, 1'b0, 10'h3FF);
        convert(10'h1FF, 1'b1, 10'h200);
        convert(10'h2AA, 1'b0, 10'h1FF);
        convert(10'h155, 1'b1, 10'h2AA);
        convert(10'h001, 1'b0, 10'h155);

        repeat (2) @(negedge clk);
        check(exp_bits.size() == 0, "R5 all bits seen", exp_bits.size(), 0);
        check(exp_res.size() == 0, "R4 all codes seen", exp_res.size(), 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule